// File: doc/BRIEF.md
# Mixed-Width Global Control Register Bank

This block is a bank of 32-bit control and status registers behind a single-cycle request/response port. A request carries a byte offset, a write flag, an access size in bytes and up to 64 bits of write data. The response comes back one clock later with read data and an error bit. The register index is the byte offset divided by four.

Every register has a write policy fixed by a parameter: plain read/write, read-only, write-1-to-clear or write-1-to-set. Word (4-byte) accesses reach every register and apply that policy. Doubleword (8-byte) accesses are accepted only inside a scratchpad window at the top of the bank. There they join two neighbouring registers on a read, or split the data across them on a write, with no policy applied. Every access is checked for legality. An illegal access returns an error, reads as zero and changes nothing. A word write to a read-only register is legal but is dropped, and it raises a one-cycle flag.

The register count, the scratchpad start index, the per-register policy vector and the reset-value vector are all parameters. The defaults give 24 registers:

- Registers 0 to 2 are read-only, with reset values 0x0A5C0001, 0x00001234 and 0x00000010.
- Register 3 is write-1-to-clear, with reset value 0x80000007.
- Registers 4 and 5 are write-1-to-set, with reset value 0.
- Register 6 is read/write, with reset value 0x000000FF.
- All other registers are read/write, with reset value 0.
- The scratchpad window starts at register 16.

Top module: `ctl_regbank`

## Requirements
- R1: A request with `req_valid` high produces `rsp_valid` high on the next cycle. A legal word read returns the addressed register in `rsp_rdata[31:0]`, with bits 63:32 zero.
- R2: After reset, each register holds its parameterised reset value, and all response outputs are zero.
- R3: A word write to a read-only register leaves the register unchanged. It pulses `ro_write_flag` with the response and does not set `rsp_err`.
- R4: A word write to a write-1-to-clear register stores `old & ~wdata`.
- R5: A word write to a write-1-to-set register stores `old | wdata`, so set bits cannot be cleared by a word write.
- R6: A word write to a read/write register stores `wdata[31:0]`.
- R7: A legal doubleword read at register N returns register N in bits 31:0 and register N+1 in bits 63:32.
- R8: A legal doubleword write at register N stores `wdata[31:0]` into N and `wdata[63:32]` into N+1, with no policy applied.
- R9: A doubleword access is legal only when all three conditions hold: the offset is a multiple of 8, the offset is at least 4*SCR_BASE, and the offset is below 4*(NREG-1). Any other doubleword access is an error.
- R10: An access is an error if any of the following holds: its size is neither 4 nor 8, a word offset is not a multiple of 4, or the offset is at or above 4*NREG. An error response has `rsp_rdata` zero and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset into the bank |
| req_size | input | 4 | Access size in bytes (legal: 4 or 8) |
| req_wdata | input | 64 | Write data; bits 63:32 used only by doubleword writes |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Previous request was illegal |
| ro_write_flag | output | 1 | Previous request was a word write to a read-only register |

## Verification
All four response outputs are registered once. They are therefore due exactly one clock after the edge that takes the request, and register updates land on that same edge, so a read issued in the following cycle sees them. The bench drives each request on a falling edge. At the next falling edge it compares all four outputs against the result its behavioural model computed for that request. It then applies the model's register update before predicting the following request. Back-to-back writes and reads therefore check both the one-cycle response and the same-edge state update, including the pairing of registers N and N+1.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;

  typedef enum logic [1:0] {
    POL_RW  = 2'd0,
    POL_RO  = 2'd1,
    POL_W1C = 2'd2,
    POL_W1S = 2'd3
  } reg_policy_e;

  localparam int          DEF_NREG = 24;
  localparam logic [3:0]  SZ_WORD  = 4'd4;
  localparam logic [3:0]  SZ_DWORD = 4'd8;

  function automatic logic [2*DEF_NREG-1:0] default_policy();
    logic [2*DEF_NREG-1:0] v;
    v = '0;
    for (int i = 0; i < DEF_NREG; i++) begin
      if (i <= 2)      v[2*i +: 2] = POL_RO;
      else if (i == 3) v[2*i +: 2] = POL_W1C;
      else if (i <= 5) v[2*i +: 2] = POL_W1S;
      else             v[2*i +: 2] = POL_RW;
    end
    return v;
  endfunction

  function automatic logic [32*DEF_NREG-1:0] default_reset();
    logic [32*DEF_NREG-1:0] v;
    v = '0;
    v[32*0 +: 32] = 32'h0A5C_0001;
    v[32*1 +: 32] = 32'h0000_1234;
    v[32*2 +: 32] = 32'h0000_0010;
    v[32*3 +: 32] = 32'h8000_0007;
    v[32*6 +: 32] = 32'h0000_00FF;
    return v;
  endfunction

  // New register value after a word write under a given policy.
  function automatic logic [31:0] apply_policy(reg_policy_e p, logic [31:0] cur,
                                               logic [31:0] wd);
    case (p)
      POL_RO:  return cur;
      POL_W1C: return cur & ~wd;
      POL_W1S: return cur | wd;
      default: return wd;
    endcase
  endfunction

  // Legality of an access given its byte offset and size.
  function automatic logic access_ok(int unsigned off, logic [3:0] size,
                                     int unsigned nreg, int unsigned scr);
    if (off >= nreg * 4) return 1'b0;
    if (size == SZ_WORD)  return (off % 4) == 0;
    if (size == SZ_DWORD) return ((off % 8) == 0) && (off >= scr * 4) &&
                                 (off < (nreg - 1) * 4);
    return 1'b0;
  endfunction

endpackage

// File: rtl/ctl_access_check.sv
module ctl_access_check
  import ctl_regbank_pkg::*;
#(
  parameter int NREG     = 24,
  parameter int SCR_BASE = 16,
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output logic              acc_ok,
  output logic              rd,
  output logic              wr32,
  output logic              wr64,
  output logic              is_dw,
  output logic [IDX_W-1:0]  idx
);

  assign acc_ok = access_ok(32'(req_addr), req_size, NREG, SCR_BASE);
  assign is_dw  = (req_size == SZ_DWORD);
  assign idx    = IDX_W'(req_addr >> 2);
  assign rd     = req_valid && acc_ok && !req_write;
  assign wr32   = req_valid && acc_ok && req_write && !is_dw;
  assign wr64   = req_valid && acc_ok && req_write && is_dw;

  // A doubleword write that gets through must sit inside the scratchpad, leaving room for N+1.
  assert_dw_in_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr64 |-> ((32'(idx) >= SCR_BASE) && (32'(idx) + 1 < NREG) && (idx[0] == 1'b0)));

endmodule

// File: rtl/ctl_reg_slice.sv
module ctl_reg_slice
  import ctl_regbank_pkg::*;
#(
  parameter reg_policy_e POL = POL_RW,
  parameter logic [31:0] RST = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pol_we,
  input  logic        raw_we,
  input  logic [31:0] wdata,
  output logic [31:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= RST;
    else if (raw_we) q <= wdata;
    else if (pol_we) q <= apply_policy(POL, q, wdata);
  end

  generate
    if (POL == POL_RO) begin : g_ro
      assert_ro_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_we && !raw_we) |=> $stable(q));
    end else if (POL == POL_W1C) begin : g_w1c
      assert_w1c_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_we && !raw_we) |=> ((q & ~$past(q)) == 32'h0));
    end else if (POL == POL_W1S) begin : g_w1s
      assert_w1s_no_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_we && !raw_we) |=> (($past(q) & ~q) == 32'h0));
    end
  endgenerate

endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux #(
  parameter int NREG  = 24,
  parameter int IDX_W = 5
) (
  input  logic [32*NREG-1:0] regs_flat,
  input  logic [IDX_W-1:0]   idx,
  input  logic               wide,
  output logic [63:0]        rdata
);

  logic [31:0] lo, hi;

  always_comb begin
    lo = 32'h0;
    hi = 32'h0;
    for (int i = 0; i < NREG; i++) begin
      if (idx == IDX_W'(i)) begin
        lo = regs_flat[32*i +: 32];
        if (i + 1 < NREG) hi = regs_flat[32*(i+1) +: 32];
      end
    end
    rdata = wide ? {hi, lo} : {32'h0, lo};
  end

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter int                     NREG     = DEF_NREG,
  parameter int                     SCR_BASE = 16,
  parameter int                     ADDR_W   = 8,
  parameter logic [2*NREG-1:0]      POLICY   = default_policy(),
  parameter logic [32*NREG-1:0]     RST_VAL  = default_reset()
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              ro_write_flag
);

  localparam int IDX_W = $clog2(NREG);

  logic             acc_ok, rd, wr32, wr64, is_dw;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   idx_nx;
  logic [32*NREG-1:0] regs_flat;
  logic [63:0]      rd_data;
  logic             ro_hit;

  ctl_access_check #(
    .NREG(NREG), .SCR_BASE(SCR_BASE), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_check (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size),
    .acc_ok(acc_ok), .rd(rd), .wr32(wr32), .wr64(wr64),
    .is_dw(is_dw), .idx(idx)
  );

  assign idx_nx = {1'b0, idx} + (IDX_W+1)'(1);

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_reg
      logic        pol_we, raw_we;
      logic [31:0] slice_wd, q;
      assign pol_we   = wr32 && (idx == IDX_W'(i));
      assign raw_we   = wr64 && ((idx == IDX_W'(i)) || (idx_nx == (IDX_W+1)'(i)));
      assign slice_wd = (wr64 && (idx_nx == (IDX_W+1)'(i))) ? req_wdata[63:32]
                                                            : req_wdata[31:0];
      ctl_reg_slice #(
        .POL(reg_policy_e'(POLICY[2*i +: 2])),
        .RST(RST_VAL[32*i +: 32])
      ) u_slice (
        .clk(clk), .rst_n(rst_n),
        .pol_we(pol_we), .raw_we(raw_we),
        .wdata(slice_wd), .q(q)
      );
      assign regs_flat[32*i +: 32] = q;
    end
  endgenerate

  ctl_read_mux #(.NREG(NREG), .IDX_W(IDX_W)) u_rmux (
    .regs_flat(regs_flat), .idx(idx), .wide(is_dw), .rdata(rd_data)
  );

  assign ro_hit = wr32 && (reg_policy_e'(POLICY[2*idx +: 2]) == POL_RO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= 64'h0;
      rsp_err       <= 1'b0;
      ro_write_flag <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_rdata     <= rd ? rd_data : 64'h0;
      rsp_err       <= req_valid && !acc_ok;
      ro_write_flag <= ro_hit;
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_err_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 64'h0));

  assert_bad_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |=> $stable(regs_flat));

  assert_ro_flag_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write_flag |-> (rsp_valid && !rsp_err));

  assert_idle_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(regs_flat));

endmodule

// File: tb/ctl_regbank_bench.sv
module ctl_regbank_bench;

  localparam int N   = 24;
  localparam int SCR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = 8'h0;
  logic [3:0]  req_size = 4'd4;
  logic [63:0] req_wdata = 64'h0;
  logic        rsp_valid, rsp_err, ro_write_flag;
  logic [63:0] rsp_rdata;

  always #10 clk = ~clk;

  ctl_regbank u_ctl_regbank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .ro_write_flag(ro_write_flag)
  );

  int checks = 0, errors = 0;
  logic [31:0] mdl [N];
  logic        e_valid = 0, e_err = 0, e_ro = 0;
  logic [63:0] e_rdata = 0;
  string       e_tag = "R2";
  bit          done = 0;

  // Policy kinds: 0 rw, 1 ro, 2 w1c, 3 w1s
  function automatic int kind_of(int r);
    if (r < 3) return 1;
    if (r == 3) return 2;
    if (r == 4 || r == 5) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] boot_val(int r);
    case (r)
      0: return 32'h0A5C0001;
      1: return 32'h00001234;
      2: return 32'h00000010;
      3: return 32'h80000007;
      6: return 32'h000000FF;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", e_tag, what, got, exp);
    end
  endtask

  // One cycle: check the previous response, then drive and predict the next one.
  task automatic step(bit v, bit w, int addr, int size, logic [63:0] wd, string tag);
    int r;
    bit ok;
    string t;
    @(negedge clk);
    chk("rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk("rsp_err", 64'(rsp_err), 64'(e_err));
    chk("rsp_rdata", rsp_rdata, e_rdata);
    chk("ro_write_flag", 64'(ro_write_flag), 64'(e_ro));
    req_valid = v; req_write = w; req_addr = addr[7:0];
    req_size = size[3:0]; req_wdata = wd;
    e_valid = v; e_err = 0; e_ro = 0; e_rdata = 0; t = "R6";
    if (v) begin
      r  = addr / 4;
      ok = (addr < 4 * N) &&
           ((size == 4 && addr % 4 == 0) ||
            (size == 8 && addr % 8 == 0 && r >= SCR && r + 1 < N));
      if (!ok) begin
        e_err = 1; t = (size == 8) ? "R9" : "R10";
      end else if (!w) begin
        if (size == 8) begin e_rdata = {mdl[r+1], mdl[r]}; t = "R7"; end
        else begin e_rdata = {32'h0, mdl[r]}; t = "R1"; end
      end else if (size == 8) begin
        mdl[r] = wd[31:0]; mdl[r+1] = wd[63:32]; t = "R8";
      end else begin
        case (kind_of(r))
          1: begin e_ro = 1; t = "R3"; end
          2: begin mdl[r] = mdl[r] & ~wd[31:0]; t = "R4"; end
          3: begin mdl[r] = mdl[r] | wd[31:0]; t = "R5"; end
          default: begin mdl[r] = wd[31:0]; t = "R6"; end
        endcase
      end
    end
    e_tag = (tag != "") ? tag : t;
  endtask

  task automatic rd4(int r, string tag = "");  step(1, 0, 4*r, 4, 64'h0, tag); endtask
  task automatic wr4(int r, logic [31:0] d);   step(1, 1, 4*r, 4, {32'h0, d}, ""); endtask

  initial begin
    repeat (20 * 200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mdl[i] = boot_val(i);
    repeat (3) @(negedge clk);
    e_tag = "R2";
    chk("reset rsp_valid", 64'(rsp_valid), 64'h0);
    chk("reset rsp_err", 64'(rsp_err), 64'h0);
    chk("reset rsp_rdata", rsp_rdata, 64'h0);
    rst_n = 1'b1;
    // R2: every register reads back its reset value
    for (int i = 0; i < N; i++) rd4(i, "R2");
    // R3: read-only registers ignore writes
    for (int i = 0; i < 3; i++) wr4(i, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) rd4(i);
    // R4: write-1-to-clear
    wr4(3, 32'h0000_0005); rd4(3); wr4(3, 32'h8000_0000); rd4(3);
    // R5: write-1-to-set
    wr4(4, 32'h0000_000F); wr4(4, 32'h0000_00F0); rd4(4); wr4(4, 32'h0); rd4(4);
    wr4(5, 32'h8000_0001); rd4(5);
    // R6: plain read/write, back-to-back
    wr4(8, 32'hDEAD_BEEF); rd4(8); wr4(8, 32'h0000_1234); rd4(8);
    // R8 / R7: doubleword split and join
    step(1, 1, 64, 8, 64'h1111_2222_3333_4444, "");
    rd4(16); rd4(17);
    step(1, 0, 64, 8, 64'h0, "");
    step(1, 1, 88, 8, 64'hA5A5_0000_0000_5A5A, "");
    step(1, 0, 88, 8, 64'h0, ""); rd4(23);
    wr4(18, 32'hCAFE_0001); wr4(19, 32'hCAFE_0002);
    step(1, 0, 72, 8, 64'h0, "");
    // R9: doubleword outside the window, misaligned, or touching the last register
    step(1, 0, 32, 8, 64'h0, "");
    step(1, 1, 32, 8, 64'hFFFF_FFFF_FFFF_FFFF, ""); rd4(8); rd4(9);
    step(1, 0, 68, 8, 64'h0, "");
    step(1, 1, 68, 8, 64'h0, ""); rd4(17); rd4(18);
    step(1, 0, 92, 8, 64'h0, "");
    step(1, 0, 96, 8, 64'h0, "");
    step(1, 1, 12, 8, 64'hFFFF_FFFF_FFFF_FFFF, ""); rd4(3); rd4(4);
    // R10: bad size, unaligned word, out of range
    step(1, 0, 33, 4, 64'h0, "");
    step(1, 1, 34, 4, 64'h0, ""); rd4(8);
    step(1, 1, 32, 2, 64'h0, ""); rd4(8);
    step(1, 0, 32, 0, 64'h0, "");
    step(1, 1, 96, 4, 64'h0, "");
    step(1, 0, 252, 4, 64'h0, "");
    step(0, 1, 32, 4, 64'h0, "R6"); rd4(8);
    // Mixed random traffic against the model
    for (int k = 0; k < 400; k++) begin
      int a, s;
      a = ($urandom % 8 == 0) ? int'($urandom % 110) : 4 * int'($urandom % 26);
      s = ($urandom % 3 == 0) ? 8 : (($urandom % 16 == 0) ? 2 : 4);
      step($urandom % 8 != 0, $urandom % 2 == 1, a, s,
           {$urandom, $urandom}, "");
    end
    step(0, 0, 0, 4, 64'h0, "");
    step(0, 0, 0, 4, 64'h0, "");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule